// File: doc/BRIEF.md
# Multi-Scheme Protected Register File

This block is a register file of 32 words of 32 bits. Every write chooses the protection for the word it stores. The choices are no protection, a single-error-correcting and double-error-detecting code, three copies with a bitwise majority vote, two plain copies, or two copies that each carry the code. All copies and check bits are always written. The chosen scheme is stored with the word, so a later read decodes it the way it was written.

On a read, a checker rebuilds the word from its copies. It corrects the word where the scheme allows. It raises a corrected flag or an uncorrected flag, which a counting unit can consume.

A second port is a simple strobe/acknowledge bus port. It can read the primary data word of any register and overwrite it. The check bits and the extra copies stay as they were. This lets a test inject bit flips that the checker must then catch. A select input chooses which port is live, and the other port is ignored completely.

Top module: `prot_regfile`

## Requirements
- R1: After reset every register reads as 0 under scheme code 0. `rd_valid`, `flag_corr`, `flag_uncorr` and `bus_ack` are low.
- R2: With `bus_sel`=0, a write (`op_we`) stores `op_wdata` and the scheme code `op_scheme`. A read (`op_re`) raises `rd_valid` one cycle later and returns the stored value. Both flags are low when the word is undisturbed, whatever the scheme.
- R3: Scheme code 0 (unprotected) returns the primary data word as stored, including injected flips, and never raises a flag.
- R4: Scheme code 1 (coded) corrects any single flipped data bit and raises `flag_corr`. With two flipped data bits it raises `flag_uncorr` and returns the primary word unchanged.
- R5: Scheme code 2 (triple) outvotes a corrupted primary copy, returns the original value and raises `flag_corr`.
- R6: Scheme code 3 (pair) raises `flag_uncorr` when the two copies differ, and returns the primary copy.
- R7: Scheme code 4 (coded pair) corrects a single flip in the primary copy from its own code. When the primary copy holds two flips, the corrected shadow copy is returned instead. Both cases raise `flag_corr` only. The two flags are never high together.
- R8: Scheme codes 5 to 7 behave as scheme 0.
- R9: With `bus_sel`=1 the operating port is ignored: no `rd_valid`, and writes are dropped.
- R10: With `bus_sel`=0 the bus port is ignored: no `bus_ack`, and writes are dropped.
- R11: Register n sits at byte offset 0x10_0000 + 4·n. With `bus_sel`=1, a strobe is acknowledged one cycle later. A bus read returns the primary data word. A bus write replaces only that word, leaving check bits and copies untouched.
- R12: A strobe to any other offset is still acknowledged, reads 0, and its write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 1 = bus port live, 0 = operating port live |
| op_we | input | 1 | Operating port write strobe |
| op_re | input | 1 | Operating port read strobe |
| op_addr | input | 5 | Register index |
| op_scheme | input | 3 | Protection scheme code for a write |
| op_wdata | input | 32 | Write data |
| rd_data | output | 32 | Checked read data |
| rd_valid | output | 1 | Read result valid |
| flag_corr | output | 1 | Read was corrected |
| flag_uncorr | output | 1 | Read holds an uncorrectable error |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 24 | Bus byte offset within the window |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data |
| bus_ack | output | 1 | Bus acknowledge |

## Verification
A read result, with its valid and flags, is registered one cycle after the `op_re` edge. A bus acknowledge and its read data are registered one cycle after the strobe edge.

The bench drives every stimulus for exactly one clock from a falling edge. It samples at the next falling edge, halfway into the cycle where the registered result appears. A write lands on the same rising edge, so a read issued right after it sees the new word. Injection is done with a bus write followed by a switch back to the operating port and a read. The expected data and flags follow from the scheme table alone.

// File: rtl/prot_regfile_pkg.sv
package prot_regfile_pkg;
    localparam int DW  = 32;
    localparam int PW  = 6;
    localparam int CBW = PW + 1;
    localparam int CWL = DW + PW;

    typedef enum logic [2:0] {
        SCH_PLAIN  = 3'd0,
        SCH_CODED  = 3'd1,
        SCH_TRIPLE = 3'd2,
        SCH_PAIR   = 3'd3,
        SCH_PAIRC  = 3'd4
    } scheme_e;

    typedef struct packed {
        logic [2:0]     scheme;
        logic [DW-1:0]  d0;
        logic [CBW-1:0] c0;
        logic [DW-1:0]  d1;
        logic [CBW-1:0] c1;
        logic [DW-1:0]  d2;
    } slot_t;

    function automatic logic [CWL:1] spread(input logic [DW-1:0] d);
        int k;
        k = 0;
        spread = '0;
        for (int i = 1; i <= CWL; i++) begin
            if ((i & (i - 1)) != 0) begin
                spread[i] = d[k];
                k++;
            end
        end
    endfunction

    function automatic logic [DW-1:0] gather(input logic [CWL:1] cw);
        int k;
        k = 0;
        gather = '0;
        for (int i = 1; i <= CWL; i++) begin
            if ((i & (i - 1)) != 0) begin
                gather[k] = cw[i];
                k++;
            end
        end
    endfunction

    function automatic logic [PW-1:0] syndrome(input logic [CWL:1] cw);
        syndrome = '0;
        for (int i = 1; i <= CWL; i++) begin
            if (cw[i]) syndrome = syndrome ^ PW'(i);
        end
    endfunction
endpackage

// File: rtl/prot_code_enc.sv
module prot_code_enc
    import prot_regfile_pkg::*;
(
    input  logic [DW-1:0]  data_i,
    output logic [CBW-1:0] check_o
);
    logic [PW-1:0] par;
    always_comb begin
        par     = syndrome(spread(data_i));
        check_o = {(^data_i) ^ (^par), par};
    end
endmodule

// File: rtl/prot_code_dec.sv
module prot_code_dec
    import prot_regfile_pkg::*;
(
    input  logic [DW-1:0]  data_i,
    input  logic [CBW-1:0] check_i,
    output logic [DW-1:0]  data_o,
    output logic           corr_o,
    output logic           unc_o
);
    logic [CWL:1]  cw;
    logic [PW-1:0] syn;
    logic          odd;

    always_comb begin
        cw = spread(data_i);
        for (int k = 0; k < PW; k++) cw[1 << k] = check_i[k];
        syn = syndrome(cw);
        odd = ^{data_i, check_i};
        if (odd && syn != '0 && syn <= PW'(CWL)) cw[syn] = ~cw[syn];
        data_o = gather(cw);
        corr_o = odd && (syn <= PW'(CWL));
        unc_o  = (!odd && syn != '0) || (odd && syn > PW'(CWL));
    end
endmodule

// File: rtl/prot_read_check.sv
module prot_read_check
    import prot_regfile_pkg::*;
(
    input  slot_t         slot_i,
    output logic [DW-1:0] data_o,
    output logic          corr_o,
    output logic          unc_o
);
    logic [1:0][DW-1:0]  cp_d;
    logic [1:0][CBW-1:0] cp_c;
    logic [1:0][DW-1:0]  fx_d;
    logic [1:0]          fx_corr;
    logic [1:0]          fx_unc;
    logic [DW-1:0]       vote;

    assign cp_d = {slot_i.d1, slot_i.d0};
    assign cp_c = {slot_i.c1, slot_i.c0};

    for (genvar g = 0; g < 2; g++) begin : g_dec
        prot_code_dec u_dec (
            .data_i (cp_d[g]),
            .check_i(cp_c[g]),
            .data_o (fx_d[g]),
            .corr_o (fx_corr[g]),
            .unc_o  (fx_unc[g])
        );
    end

    assign vote = (slot_i.d0 & slot_i.d1) | (slot_i.d0 & slot_i.d2) | (slot_i.d1 & slot_i.d2);

    always_comb begin
        data_o = slot_i.d0;
        corr_o = 1'b0;
        unc_o  = 1'b0;
        case (slot_i.scheme)
            SCH_CODED: begin
                data_o = fx_d[0];
                corr_o = fx_corr[0];
                unc_o  = fx_unc[0];
            end
            SCH_TRIPLE: begin
                data_o = vote;
                corr_o = (slot_i.d0 != slot_i.d1) || (slot_i.d0 != slot_i.d2);
            end
            SCH_PAIR: begin
                unc_o = (slot_i.d0 != slot_i.d1);
            end
            SCH_PAIRC: begin
                if (!fx_unc[0]) begin
                    data_o = fx_d[0];
                    corr_o = fx_corr[0];
                end else if (!fx_unc[1]) begin
                    data_o = fx_d[1];
                    corr_o = 1'b1;
                end else begin
                    unc_o = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prot_regfile.sv
module prot_regfile
    import prot_regfile_pkg::*;
#(
    parameter int          NREGS  = 32,
    parameter int          BUS_AW = 24,
    parameter logic [23:0] WIN    = 24'h10_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              op_we,
    input  logic              op_re,
    input  logic [$clog2(NREGS)-1:0] op_addr,
    input  logic [2:0]        op_scheme,
    input  logic [DW-1:0]     op_wdata,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              flag_corr,
    output logic              flag_uncorr,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_ack
);
    localparam int IW = $clog2(NREGS);
    localparam int LO = IW + 2;

    typedef struct packed {
        slot_t [NREGS-1:0] slots;
        logic [DW-1:0]     rd_data;
        logic              rd_valid;
        logic              corr;
        logic              unc;
        logic              ack;
        logic [DW-1:0]     brdata;
    } state_t;

    state_t         st_d, st_q;
    logic [CBW-1:0] wr_chk;
    logic [DW-1:0]  chk_data;
    logic           chk_corr, chk_unc;
    logic           bus_hit;
    logic [IW-1:0]  bus_idx;

    prot_code_enc u_enc (
        .data_i (op_wdata),
        .check_o(wr_chk)
    );

    prot_read_check u_chk (
        .slot_i(st_q.slots[op_addr]),
        .data_o(chk_data),
        .corr_o(chk_corr),
        .unc_o (chk_unc)
    );

    assign bus_hit = (bus_addr[BUS_AW-1:LO] == WIN[BUS_AW-1:LO]) && (bus_addr[1:0] == 2'b00);
    assign bus_idx = bus_addr[LO-1:2];

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.corr     = 1'b0;
        st_d.unc      = 1'b0;
        st_d.ack      = 1'b0;
        if (!bus_sel) begin
            if (op_re) begin
                st_d.rd_valid = 1'b1;
                st_d.rd_data  = chk_data;
                st_d.corr     = chk_corr;
                st_d.unc      = chk_unc;
            end
            if (op_we) begin
                st_d.slots[op_addr].scheme = op_scheme;
                st_d.slots[op_addr].d0     = op_wdata;
                st_d.slots[op_addr].d1     = op_wdata;
                st_d.slots[op_addr].d2     = op_wdata;
                st_d.slots[op_addr].c0     = wr_chk;
                st_d.slots[op_addr].c1     = wr_chk;
            end
        end else if (bus_stb) begin
            st_d.ack    = 1'b1;
            st_d.brdata = bus_hit ? st_q.slots[bus_idx].d0 : '0;
            if (bus_we && bus_hit) st_d.slots[bus_idx].d0 = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data     = st_q.rd_data;
    assign rd_valid    = st_q.rd_valid;
    assign flag_corr   = st_q.corr;
    assign flag_uncorr = st_q.unc;
    assign bus_rdata   = st_q.brdata;
    assign bus_ack     = st_q.ack;

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_corr && flag_uncorr));
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (op_re && !bus_sel) |=> rd_valid);
    a_r2_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_corr || flag_uncorr) |-> rd_valid);
    a_r9_op_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> !rd_valid);
    a_r10_bus_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_ack);
    a_r11_bus_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_stb) |=> bus_ack);
endmodule

// File: tb/prot_regfile_tb_top.sv
`timescale 1ns/1ps
module prot_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        op_we = 1'b0, op_re = 1'b0;
    logic [4:0]  op_addr = '0;
    logic [2:0]  op_scheme = '0;
    logic [31:0] op_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid, flag_corr, flag_uncorr;
    logic        bus_stb = 1'b0, bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prot_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
        .op_we(op_we), .op_re(op_re), .op_addr(op_addr),
        .op_scheme(op_scheme), .op_wdata(op_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .flag_corr(flag_corr), .flag_uncorr(flag_uncorr),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op_wr(input int a, input int s, input logic [31:0] v);
        @(negedge clk);
        op_we = 1'b1; op_addr = 5'(a); op_scheme = 3'(s); op_wdata = v;
        @(negedge clk);
        op_we = 1'b0;
    endtask

    // Sample at the negedge after the strobe cycle: result registered one cycle later.
    task automatic op_rd(input int a, output logic [31:0] d, output logic v, output logic c, output logic u);
        @(negedge clk);
        op_re = 1'b1; op_addr = 5'(a);
        @(negedge clk);
        op_re = 1'b0;
        d = rd_data; v = rd_valid; c = flag_corr; u = flag_uncorr;
    endtask

    task automatic bus_x(input logic we, input logic [23:0] ad, input logic [31:0] wd,
                         output logic ack, output logic [31:0] rd);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = we; bus_addr = ad; bus_wdata = wd;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
        ack = bus_ack; rd = bus_rdata;
    endtask

    function automatic logic [23:0] reg_off(input int n);
        return 24'h10_0000 + 24'(4 * n);
    endfunction

    function automatic logic [31:0] pat(input int r, input int s);
        return 32'h5A3C_96E1 ^ (32'(r) * 32'h0101_0101) ^ (32'(s) << 27);
    endfunction

    // Overwrite primary word of register r through the bus, then return to the operating port.
    task automatic inject(input int r, input logic [31:0] v);
        logic a; logic [31:0] x;
        @(negedge clk); bus_sel = 1'b1;
        bus_x(1'b1, reg_off(r), v, a, x);
        @(negedge clk); bus_sel = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic v, c, u, a;
        logic [31:0] x, orig;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!rd_valid && !flag_corr && !flag_uncorr && !bus_ack, "R1 outputs", {28'd0, rd_valid, flag_corr, flag_uncorr, bus_ack}, 32'd0);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r += 7) begin
            op_rd(r, d, v, c, u);
            chk(v && d == 0 && !c && !u, "R1 reset value", d, 32'd0);
        end
        // R2: every register under every scheme, clean reads
        for (int r = 0; r < 32; r++) begin
            for (int s = 0; s < 5; s++) begin
                op_wr(r, s, pat(r, s));
                op_rd(r, d, v, c, u);
                chk(v && d == pat(r, s) && !c && !u, "R2 clean read", d, pat(r, s));
            end
        end
        // R3 and R8: unprotected schemes expose injected data without flags
        for (int s = 0; s < 8; s++) begin
            if (s != 0 && s < 5) continue;
            orig = pat(3, s);
            op_wr(3, s, orig);
            inject(3, orig ^ 32'h0000_0101);
            op_rd(3, d, v, c, u);
            chk(d == (orig ^ 32'h0000_0101) && !c && !u, s == 0 ? "R3 plain inject" : "R8 spare code", d, orig ^ 32'h0000_0101);
        end
        // R4: single flips on every bit are corrected, doubles detected
        for (int b = 0; b < 32; b++) begin
            orig = pat(5, b);
            op_wr(5, 1, orig);
            inject(5, orig ^ (32'd1 << b));
            op_rd(5, d, v, c, u);
            chk(d == orig && c && !u, "R4 single corrected", d, orig);
            op_wr(5, 1, orig);
            inject(5, orig ^ (32'd1 << b) ^ (32'd1 << ((b + 9) % 32)));
            op_rd(5, d, v, c, u);
            chk(u && !c && d == (orig ^ (32'd1 << b) ^ (32'd1 << ((b + 9) % 32))), "R4 double detected", d, orig ^ (32'd1 << b) ^ (32'd1 << ((b + 9) % 32)));
        end
        // R5: triple vote
        for (int b = 0; b < 32; b += 5) begin
            orig = pat(9, b);
            op_wr(9, 2, orig);
            inject(9, ~orig);
            op_rd(9, d, v, c, u);
            chk(d == orig && c && !u, "R5 vote", d, orig);
        end
        // R6: pair mismatch
        orig = pat(11, 0);
        op_wr(11, 3, orig);
        inject(11, orig ^ 32'h8000_0000);
        op_rd(11, d, v, c, u);
        chk(d == (orig ^ 32'h8000_0000) && u && !c, "R6 pair mismatch", d, orig ^ 32'h8000_0000);
        // R7: coded pair single and double in primary
        for (int b = 0; b < 32; b += 3) begin
            orig = pat(13, b);
            op_wr(13, 4, orig);
            inject(13, orig ^ (32'd1 << b));
            op_rd(13, d, v, c, u);
            chk(d == orig && c && !u, "R7 primary single", d, orig);
            op_wr(13, 4, orig);
            inject(13, orig ^ (32'd3 << (b % 31)));
            op_rd(13, d, v, c, u);
            chk(d == orig && c && !u, "R7 shadow fallback", d, orig);
        end
        // R11: bus read of primary word and acknowledge
        op_wr(20, 1, 32'hCAFE_0020);
        @(negedge clk); bus_sel = 1'b1;
        bus_x(1'b0, reg_off(20), 32'd0, a, x);
        chk(a && x == 32'hCAFE_0020, "R11 bus read", x, 32'hCAFE_0020);
        bus_x(1'b0, reg_off(31), 32'd0, a, x);
        chk(a && x == pat(31, 4), "R11 bus read last", x, pat(31, 4));
        // R12: unmapped offsets
        bus_x(1'b1, 24'h00_0050, 32'hFFFF_FFFF, a, x);
        chk(a && x == 0, "R12 unmapped write ack", x, 32'd0);
        bus_x(1'b0, 24'h10_0080, 32'd0, a, x);
        chk(a && x == 0, "R12 unmapped read", x, 32'd0);
        bus_x(1'b0, 24'h10_0051, 32'd0, a, x);
        chk(a && x == 0, "R12 misaligned read", x, 32'd0);
        // R9: operating port ignored while bus live
        op_wr(20, 0, 32'h1111_1111);
        op_rd(20, d, v, c, u);
        chk(!v, "R9 no read valid", {31'd0, v}, 32'd0);
        bus_x(1'b0, reg_off(20), 32'd0, a, x);
        chk(x == 32'hCAFE_0020, "R9 write dropped", x, 32'hCAFE_0020);
        @(negedge clk); bus_sel = 1'b0;
        op_rd(20, d, v, c, u);
        chk(d == 32'hCAFE_0020 && !c && !u, "R12 no side effect", d, 32'hCAFE_0020);
        // R10: bus port ignored while operating port live
        bus_x(1'b1, reg_off(20), 32'h2222_2222, a, x);
        chk(!a, "R10 no ack", {31'd0, a}, 32'd0);
        op_rd(20, d, v, c, u);
        chk(d == 32'hCAFE_0020 && !c, "R10 write dropped", d, 32'hCAFE_0020);
        // R11: bus write touches only primary word of coded slot
        inject(20, 32'hCAFE_0021);
        op_rd(20, d, v, c, u);
        chk(d == 32'hCAFE_0020 && c, "R11 check bits kept", d, 32'hCAFE_0020);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule